// File: doc/BRIEF.md
# Privileged Interrupt Selector

This block decides, each cycle, whether the hart should take an interrupt and which cause number to report for it. It takes the raw pending vector, the per-source enable vector, a delegation mask, the current privilege level and the two global interrupt-enable bits for machine and supervisor level. It returns a take strobe and a cause word that is ready to go into a cause register.

Interrupts whose delegation bit is clear belong to the machine group. Interrupts whose delegation bit is set belong to the supervisor group. Each group is opened or closed by its own privilege-dependent rule. When both groups are open, the sources compete together, and the lowest-numbered enabled source wins. The block does not enter the trap, store any CSR or generate pending bits. A parameter can add one register stage on the outputs for timing.

Top module: `prv_irq_select`

## Requirements
- R1: A source is a candidate only when both its pending bit and its enable bit are 1. A source with either bit at 0 is never reported.
- R2: A candidate whose delegation bit is 0 is allowed when the privilege is user or supervisor. At machine privilege it is allowed only when the machine global enable input is 1.
- R3: A candidate whose delegation bit is 1 is allowed at user privilege. At supervisor privilege it is allowed only when the supervisor global enable input is 1. At machine privilege it is never allowed.
- R4: The allowed sets of both groups are merged. The reported source is the lowest-numbered allowed one, whichever group it belongs to.
- R5: When a source is taken, the cause word has bit XLEN-1 set to 1. Its low $clog2(XLEN) bits hold the source index, and all other bits are 0.
- R6: When no source is allowed, take_o is 0 and cause_o is all zeros.
- R7: The privilege encoding is user=0, supervisor=1, machine=3. The reserved value 2 is treated as illegal and nothing is taken while it is applied.
- R8: With REG_OUT=1 (the default), the outputs show the decision for the inputs present at the previous rising clock edge. While rst_ni is low, both outputs are 0. With REG_OUT=0, the outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | XLEN | Pending interrupt bits |
| en_i | input | XLEN | Per-source enable bits |
| deleg_i | input | XLEN | Delegation mask; 1 sends the source to the supervisor group |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| take_o | output | 1 | An interrupt is to be taken |
| cause_o | output | XLEN | Cause word with the interrupt flag in the top bit |

## Verification
The bench applies directed cases at every privilege level with each global enable both set and cleared. This separates the machine-group rule from the supervisor-group rule. It runs cases where a low-numbered source is pending but disabled, or gated off by its group, while a higher one is allowed. This tells real lowest-index selection apart from a plain lowest-pending search. It also runs cases with sources 0 and XLEN-1 alone to check both ends of the index encoding, and cases with the reserved privilege value. A long stretch of random sparse vectors is then compared, on every clock, against a loop-based reference model that applies the one-cycle output latency.

// File: rtl/prv_irq_pkg.sv
package prv_irq_pkg;
  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } lvl_e;
endpackage

// File: rtl/prv_irq_gate.sv
module prv_irq_gate #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] cand_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic [XLEN-1:0] allow_o
);
  import prv_irq_pkg::*;

  logic m_open, s_open;

  always_comb begin
    m_open = 1'b0;
    s_open = 1'b0;
    unique case (lvl_e'(priv_i))
      LVL_USER:  begin m_open = 1'b1; s_open = 1'b1;  end
      LVL_SUPER: begin m_open = 1'b1; s_open = sie_i; end
      LVL_MACH:  begin m_open = mie_i; s_open = 1'b0; end
      default:   begin m_open = 1'b0; s_open = 1'b0;  end
    endcase
  end

  assign allow_o = (cand_i & ~deleg_i & {XLEN{m_open}})
                 | (cand_i &  deleg_i & {XLEN{s_open}});
endmodule

// File: rtl/prv_irq_pick.sv
module prv_irq_pick #(
  parameter int XLEN = 64,
  localparam int IW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] vec_i,
  output logic            any_o,
  output logic [IW-1:0]   idx_o
);
  // highest-to-lowest scan so the lowest set bit is kept last
  always_comb begin
    idx_o = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = i[IW-1:0];
    end
  end

  assign any_o = |vec_i;
endmodule

// File: rtl/prv_irq_select.sv
module prv_irq_select #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int IW     = $clog2(XLEN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] pend_i,
  input  logic [XLEN-1:0] en_i,
  input  logic [XLEN-1:0] deleg_i,
  input  logic [1:0]      priv_i,
  input  logic            mie_i,
  input  logic            sie_i,
  output logic            take_o,
  output logic [XLEN-1:0] cause_o
);
  logic [XLEN-1:0] allow;
  logic            any;
  logic [IW-1:0]   idx;
  logic            take_d;
  logic [XLEN-1:0] cause_d;

  prv_irq_gate #(.XLEN(XLEN)) u_gate (
    .cand_i  (pend_i & en_i),
    .deleg_i (deleg_i),
    .priv_i  (priv_i),
    .mie_i   (mie_i),
    .sie_i   (sie_i),
    .allow_o (allow)
  );

  prv_irq_pick #(.XLEN(XLEN)) u_pick (
    .vec_i (allow),
    .any_o (any),
    .idx_o (idx)
  );

  always_comb begin
    cause_d = '0;
    if (any) begin
      cause_d[XLEN-1] = 1'b1;
      cause_d[IW-1:0] = idx;
    end
  end
  assign take_d = any;

  generate
    if (REG_OUT) begin : g_reg
      logic            take_q;
      logic [XLEN-1:0] cause_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          take_q  <= 1'b0;
          cause_q <= '0;
        end else begin
          take_q  <= take_d;
          cause_q <= cause_d;
        end
      end
      assign take_o  = take_q;
      assign cause_o = cause_q;
    end else begin : g_comb
      assign take_o  = take_d;
      assign cause_o = cause_d;
    end
  endgenerate
endmodule

// File: rtl/prv_irq_select_chk.sv
module prv_irq_select_chk #(
  parameter int XLEN    = 64,
  parameter bit REG_OUT = 1'b1,
  localparam int IW     = $clog2(XLEN)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pend_i,
  input logic [XLEN-1:0] en_i,
  input logic [XLEN-1:0] deleg_i,
  input logic [1:0]      priv_i,
  input logic            mie_i,
  input logic            sie_i,
  input logic            take_o,
  input logic [XLEN-1:0] cause_o
);
  logic [XLEN-1:0] cand_r, deleg_r;
  logic [1:0]      priv_r;
  logic            mie_r, sie_r;
  logic [IW-1:0]   idx;

  generate
    if (REG_OUT) begin : g_ref_q
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cand_r <= '0; deleg_r <= '0; priv_r <= 2'd0; mie_r <= 1'b0; sie_r <= 1'b0;
        end else begin
          cand_r <= pend_i & en_i; deleg_r <= deleg_i; priv_r <= priv_i;
          mie_r <= mie_i; sie_r <= sie_i;
        end
      end
    end else begin : g_ref_c
      assign cand_r  = pend_i & en_i;
      assign deleg_r = deleg_i;
      assign priv_r  = priv_i;
      assign mie_r   = mie_i;
      assign sie_r   = sie_i;
    end
  endgenerate

  assign idx = cause_o[IW-1:0];

  a_r1_taken_is_candidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> cand_r[idx]);
  a_r2_mach_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_r == 2'd3 && !mie_r) |-> !take_o);
  a_r3_no_deleg_at_mach: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_r == 2'd3 && take_o) |-> !deleg_r[idx]);
  a_r3_super_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_r == 2'd1 && !sie_r && take_o) |-> !deleg_r[idx]);
  a_r5_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> cause_o[XLEN-1]);
  a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (cause_o == '0));
  a_r7_reserved_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_r == 2'd2) |-> !take_o);
endmodule

bind prv_irq_select prv_irq_select_chk #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/prv_irq_select_bench.sv
`timescale 1ns/1ps
module prv_irq_select_bench;
  localparam int XLEN = 64;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [XLEN-1:0] pend_i = '0, en_i = '0, deleg_i = '0;
  logic [1:0]      priv_i = 2'd0;
  logic            mie_i = 1'b0, sie_i = 1'b0;
  logic            take_o;
  logic [XLEN-1:0] cause_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  prv_irq_select u_prv_irq_select (.*);

  function automatic logic [XLEN:0] model(logic [63:0] p, logic [63:0] e, logic [63:0] d,
                                          logic [1:0] lv, logic m, logic s);
    bit m_ok, s_ok;
    logic [63:0] c;
    m_ok = (lv == 0) || (lv == 1) || (lv == 3 && m);
    s_ok = (lv == 0) || (lv == 1 && s);
    for (int i = 0; i < 64; i++) begin
      if (p[i] && e[i] && ((d[i] && s_ok) || (!d[i] && m_ok))) begin
        c = 64'h8000_0000_0000_0000 | 64'(i);
        return {1'b1, c};
      end
    end
    return '0;
  endfunction

  task automatic check(string tag, logic [XLEN:0] exp);
    checks++;
    if ({take_o, cause_o} !== exp) begin
      failures++;
      $display("FAIL %s take=%0b cause=%h expected take=%0b cause=%h",
               tag, take_o, cause_o, exp[XLEN], exp[XLEN-1:0]);
    end
  endtask

  task automatic apply(string tag, logic [63:0] p, logic [63:0] e, logic [63:0] d,
                       logic [1:0] lv, logic m, logic s);
    @(negedge clk_i);
    pend_i = p; en_i = e; deleg_i = d; priv_i = lv; mie_i = m; sie_i = s;
    @(negedge clk_i);
    check(tag, model(p, e, d, lv, m, s));
  endtask

  initial begin
    for (int n = 0; n < 100000 && !done; n++) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8: outputs held at zero in reset even with live inputs
    pend_i = '1; en_i = '1; priv_i = 2'd0;
    repeat (3) @(negedge clk_i);
    check("R8 reset", '0);
    rst_ni = 1'b1;

    // R1: pending but disabled, enabled but not pending
    apply("R1", 64'h0F, 64'hF0, '0, 2'd0, 0, 0);
    apply("R1", 64'h30, 64'h20, '0, 2'd0, 0, 0);
    // R2: machine group at each level
    apply("R2", 64'h80, '1, '0, 2'd3, 0, 0);
    apply("R2", 64'h80, '1, '0, 2'd3, 1, 0);
    apply("R2", 64'h80, '1, '0, 2'd1, 0, 0);
    apply("R2", 64'h80, '1, '0, 2'd0, 0, 0);
    // R3: supervisor group at each level
    apply("R3", 64'h02, '1, 64'h02, 2'd3, 1, 1);
    apply("R3", 64'h02, '1, 64'h02, 2'd1, 1, 0);
    apply("R3", 64'h02, '1, 64'h02, 2'd1, 0, 1);
    apply("R3", 64'h02, '1, 64'h02, 2'd0, 0, 0);
    // R4: lower source gated off, higher one wins; mixed groups
    apply("R4", 64'h22, '1, 64'h02, 2'd3, 1, 1);
    apply("R4", 64'h22, '1, 64'h20, 2'd1, 0, 1);
    apply("R4", 64'h0C, 64'h08, '0, 2'd0, 0, 0);
    // R5: both ends of the index range
    apply("R5", 64'h1, '1, '0, 2'd0, 0, 0);
    apply("R5", 64'h8000_0000_0000_0000, '1, '0, 2'd0, 0, 0);
    // R6: nothing pending
    apply("R6", '0, '1, '0, 2'd0, 1, 1);
    // R7: reserved level blocks both groups
    apply("R7", '1, '1, 64'h5555_5555_5555_5555, 2'd2, 1, 1);
    apply("R7", '1, '1, '0, 2'd2, 1, 1);

    // random sparse stimulus, compared every clock
    for (int n = 0; n < 2000; n++) begin
      logic [63:0] p, e, d;
      p = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      e = {$urandom, $urandom} | {$urandom, $urandom};
      d = {$urandom, $urandom};
      apply("R4 random", p, e, d, 2'($urandom), 1'($urandom), 1'($urandom));
    end

    // R8: asynchronous reset clears live outputs
    apply("R8", 64'h4, '1, '0, 2'd0, 0, 0);
    #2 rst_ni = 1'b0;
    #1 check("R8 async reset", '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule